// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two N-bit ports, called A and B, that share one set of control inputs. Each transfer direction owns a storage register with its own clock. The A-to-B register samples the A input on a rising edge of `clk_a2b`. The B-to-A register samples the B input on a rising edge of `clk_b2a`. A sample is taken on every rising edge, whatever the drive controls are doing at the time. The contents stay unchanged between edges.

Two inputs decide which port is driven. `drive_en_n` is active low: while it is high, neither port is driven. While it is low, `toward_b` picks the driven port. A separate source select for each direction decides where the driven port's data comes from: either live data from the opposite port's input, or the value stored in that direction's register.

The ports are modelled as separate input, output and output-enable vectors, so no tri-state logic exists inside the block. A pad ring can build real bidirectional pins from the enable vectors. Capture and output run independently of each other. Because of this, a port that is being driven, or an isolated port pair, can still record the opposite port's data.

Top module: `dual_port_reg_xcvr`

## Requirements
- R1: On every rising edge of `clk_a2b` with `rst` low, the A-to-B register loads `a_in`, whatever the values of `drive_en_n` and `toward_b`.
- R2: On every rising edge of `clk_b2a` with `rst` low, the B-to-A register loads `b_in`, whatever the values of `drive_en_n` and `toward_b`.
- R3: While `drive_en_n` is 1, `a_oe` and `b_oe` are both all zeros.
- R4: While `drive_en_n` is 0, `toward_b` is 0 and `rst` is 0, every bit of `a_oe` is 1 and `b_oe` is all zeros.
- R5: While `drive_en_n` is 0, `toward_b` is 1 and `rst` is 0, every bit of `b_oe` is 1 and `a_oe` is all zeros.
- R6: While A is driven, `a_out` equals `b_in` when `a_use_reg` is 0, and equals the B-to-A register when `a_use_reg` is 1.
- R7: While B is driven, `b_out` equals `a_in` when `b_use_reg` is 0, and equals the A-to-B register when `b_use_reg` is 1.
- R8: `a_oe` and `b_oe` never both have a set bit in the same cycle.
- R9: A register keeps its value across any period with no rising edge on its own clock, even while the data and control inputs change.
- R10: A rising edge of a register's clock with `rst` high clears that register to zero. While `rst` is high, both enable vectors are all zeros.
- R11: Rising edges of both clocks at the same instant, with the ports isolated, load both registers at once, each from its own input port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Synchronous active-high reset, applied on the edges of each capture clock |
| clk_a2b | input | 1 | Capture clock of the A-to-B register |
| clk_b2a | input | 1 | Capture clock of the B-to-A register |
| drive_en_n | input | 1 | Active-low drive enable; 1 isolates both ports |
| toward_b | input | 1 | Driven port when enabled: 0 drives A, 1 drives B |
| b_use_reg | input | 1 | Source for B: 0 live `a_in`, 1 stored A-to-B value |
| a_use_reg | input | 1 | Source for A: 0 live `b_in`, 1 stored B-to-A value |
| a_in | input | W | Data arriving on port A |
| a_out | output | W | Data driven onto port A (meaningful only where `a_oe` is set) |
| a_oe | output | W | Per-bit drive enable of port A |
| b_in | input | W | Data arriving on port B |
| b_out | output | W | Data driven onto port B (meaningful only where `b_oe` is set) |
| b_oe | output | W | Per-bit drive enable of port B |

## Verification
The checker evaluates several properties at every edge of the capture clocks:

- each register holds the port value sampled at its previous edge;
- the two enable vectors are never active together;
- isolation clears both enable vectors;
- a driven port that selects stored data shows its register.

Some behaviour is visible only through the bench's scenarios, where the reference model compares every output on every cycle:

- retention across long gaps with no clock edge;
- simultaneous capture on both clocks;
- capture while the capturing port is itself driven;
- the reset clear, read back later through the stored-data path.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   // Which port the block is driving this cycle.
   typedef enum logic [1:0] {
      DRV_NONE = 2'd0,
      DRV_A    = 2'd1,
      DRV_B    = 2'd2
   } drive_e;

endpackage

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl
   import xcvr_pkg::*;
(
   input  logic   rst,
   input  logic   drive_en_n,
   input  logic   toward_b,
   output drive_e drive_sel
);

   always_comb begin
      if (rst || drive_en_n)
         drive_sel = DRV_NONE;
      else if (toward_b)
         drive_sel = DRV_B;
      else
         drive_sel = DRV_A;
   end

endmodule

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
   parameter int unsigned W         = 8,
   parameter bit          CLEAR_RST = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_width
      $error("xcvr_capture_reg: W must be at least 1");
   end

   if (CLEAR_RST) begin : g_clear
      always_ff @(posedge clk) begin
         if (rst) q <= '0;
         else     q <= d;
      end
   end else begin : g_plain
      logic unused_rst;
      assign unused_rst = rst;
      always_ff @(posedge clk) q <= d;
   end

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane (
   input  logic a_in_bit,
   input  logic b_in_bit,
   input  logic a2b_bit,
   input  logic b2a_bit,
   input  logic a_use_reg,
   input  logic b_use_reg,
   input  logic drv_a,
   input  logic drv_b,
   output logic a_out_bit,
   output logic b_out_bit,
   output logic a_oe_bit,
   output logic b_oe_bit
);

   always_comb begin
      a_out_bit = a_use_reg ? b2a_bit : b_in_bit;
      b_out_bit = b_use_reg ? a2b_bit : a_in_bit;
      a_oe_bit  = drv_a;
      b_oe_bit  = drv_b;
   end

endmodule

// File: rtl/dual_port_reg_xcvr.sv
module dual_port_reg_xcvr
   import xcvr_pkg::*;
#(
   parameter int unsigned W         = 8,
   parameter bit          CLEAR_RST = 1'b1
) (
   input  logic         rst,
   input  logic         clk_a2b,
   input  logic         clk_b2a,
   input  logic         drive_en_n,
   input  logic         toward_b,
   input  logic         b_use_reg,
   input  logic         a_use_reg,
   input  logic [W-1:0] a_in,
   output logic [W-1:0] a_out,
   output logic [W-1:0] a_oe,
   input  logic [W-1:0] b_in,
   output logic [W-1:0] b_out,
   output logic [W-1:0] b_oe
);

   localparam int unsigned LANES = W;

   if (W < 1) begin : g_bad_width
      $error("dual_port_reg_xcvr: W must be at least 1");
   end

   logic [W-1:0] a2b_q;
   logic [W-1:0] b2a_q;
   drive_e       drive_sel;
   logic         drv_a;
   logic         drv_b;

   xcvr_capture_reg #(.W(W), .CLEAR_RST(CLEAR_RST)) u_a2b (
      .clk (clk_a2b),
      .rst (rst),
      .d   (a_in),
      .q   (a2b_q)
   );

   xcvr_capture_reg #(.W(W), .CLEAR_RST(CLEAR_RST)) u_b2a (
      .clk (clk_b2a),
      .rst (rst),
      .d   (b_in),
      .q   (b2a_q)
   );

   xcvr_drive_ctl u_ctl (
      .rst        (rst),
      .drive_en_n (drive_en_n),
      .toward_b   (toward_b),
      .drive_sel  (drive_sel)
   );

   assign drv_a = (drive_sel == DRV_A);
   assign drv_b = (drive_sel == DRV_B);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      xcvr_lane u_lane (
         .a_in_bit  (a_in[i]),
         .b_in_bit  (b_in[i]),
         .a2b_bit   (a2b_q[i]),
         .b2a_bit   (b2a_q[i]),
         .a_use_reg (a_use_reg),
         .b_use_reg (b_use_reg),
         .drv_a     (drv_a),
         .drv_b     (drv_b),
         .a_out_bit (a_out[i]),
         .b_out_bit (b_out[i]),
         .a_oe_bit  (a_oe[i]),
         .b_oe_bit  (b_oe[i])
      );
   end

endmodule

// File: rtl/dual_port_reg_xcvr_chk.sv
module dual_port_reg_xcvr_chk #(
   parameter int unsigned W = 8
) (
   input logic         rst,
   input logic         clk_a2b,
   input logic         clk_b2a,
   input logic         drive_en_n,
   input logic         b_use_reg,
   input logic         a_use_reg,
   input logic [W-1:0] a_in,
   input logic [W-1:0] b_in,
   input logic [W-1:0] a_out,
   input logic [W-1:0] b_out,
   input logic [W-1:0] a_oe,
   input logic [W-1:0] b_oe,
   input logic [W-1:0] a2b_q,
   input logic [W-1:0] b2a_q
);

   // R1: the register shows, one edge later, what was on A at the previous edge
   a_r1_a2b_load: assert property (@(posedge clk_a2b) disable iff (rst)
      1'b1 |=> (a2b_q == $past(a_in)));

   // R2: same for the B-to-A register
   a_r2_b2a_load: assert property (@(posedge clk_b2a) disable iff (rst)
      1'b1 |=> (b2a_q == $past(b_in)));

   // R3: isolation leaves both ports undriven
   a_r3_isolated: assert property (@(posedge clk_a2b) disable iff (rst)
      drive_en_n |-> (a_oe == '0 && b_oe == '0));

   // R8: never both ports driven
   a_r8_one_port_a: assert property (@(posedge clk_a2b) disable iff (rst)
      !((|a_oe) && (|b_oe)));
   a_r8_one_port_b: assert property (@(posedge clk_b2a) disable iff (rst)
      !((|a_oe) && (|b_oe)));

   // R6: driven A with stored source shows the B-to-A register
   a_r6_a_stored: assert property (@(posedge clk_b2a) disable iff (rst)
      ((&a_oe) && a_use_reg) |-> (a_out == b2a_q));

   // R7: driven B with stored source shows the A-to-B register
   a_r7_b_stored: assert property (@(posedge clk_a2b) disable iff (rst)
      ((&b_oe) && b_use_reg) |-> (b_out == a2b_q));

endmodule

bind dual_port_reg_xcvr dual_port_reg_xcvr_chk #(.W(W)) u_chk (
   .rst        (rst),
   .clk_a2b    (clk_a2b),
   .clk_b2a    (clk_b2a),
   .drive_en_n (drive_en_n),
   .b_use_reg  (b_use_reg),
   .a_use_reg  (a_use_reg),
   .a_in       (a_in),
   .b_in       (b_in),
   .a_out      (a_out),
   .b_out      (b_out),
   .a_oe       (a_oe),
   .b_oe       (b_oe),
   .a2b_q      (a2b_q),
   .b2a_q      (b2a_q)
);

// File: tb/tb_dual_port_reg_xcvr.sv
`timescale 1ns/1ps
module tb_dual_port_reg_xcvr;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         clk_a2b = 1'b0;
   logic         clk_b2a = 1'b0;
   logic         drive_en_n = 1'b1;
   logic         toward_b = 1'b0;
   logic         b_use_reg = 1'b0;
   logic         a_use_reg = 1'b0;
   logic [W-1:0] a_in = '0;
   logic [W-1:0] b_in = '0;
   logic [W-1:0] a_out, a_oe, b_out, b_oe;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;
   bit mon_on = 1'b0;
   bit done = 1'b0;

   // behavioural reference state
   logic [W-1:0] ref_a2b = '0;
   logic [W-1:0] ref_b2a = '0;

   dual_port_reg_xcvr #(.W(W)) dut (
      .rst(rst), .clk_a2b(clk_a2b), .clk_b2a(clk_b2a),
      .drive_en_n(drive_en_n), .toward_b(toward_b),
      .b_use_reg(b_use_reg), .a_use_reg(a_use_reg),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
   );

   always #5 clk = ~clk;

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // One step: optionally pulse either capture clock shortly after clk rises.
   task automatic step(input bit pa, input bit pb);
      @(posedge clk);
      #1;
      if (pa) ref_a2b = rst ? '0 : a_in;
      if (pb) ref_b2a = rst ? '0 : b_in;
      clk_a2b = pa;
      clk_b2a = pb;
      #2;
      clk_a2b = 1'b0;
      clk_b2a = 1'b0;
      #1;
   endtask

   // Per-cycle comparison against the model (R3, R4, R5, R6, R7, R8, R10)
   always @(negedge clk) begin
      if (mon_on && !done) begin
         logic [W-1:0] e_aoe, e_boe;
         e_aoe = (!rst && !drive_en_n && !toward_b) ? '1 : '0;
         e_boe = (!rst && !drive_en_n &&  toward_b) ? '1 : '0;
         chk("R4/R3 a_oe", a_oe, e_aoe);
         chk("R5/R8 b_oe", b_oe, e_boe);
         if (e_aoe[0]) chk("R6 a_out", a_out, a_use_reg ? ref_b2a : b_in);
         if (e_boe[0]) chk("R7 b_out", b_out, b_use_reg ? ref_a2b : a_in);
      end
   end

   // Reads the stored registers through the normal output path.
   task automatic read_regs(input string tag, input logic [W-1:0] e_a2b, input logic [W-1:0] e_b2a);
      drive_en_n = 1'b0; toward_b = 1'b1; b_use_reg = 1'b1;
      #1; chk({tag, " a2b"}, b_out, e_a2b);
      toward_b = 1'b0; a_use_reg = 1'b1;
      #1; chk({tag, " b2a"}, a_out, e_b2a);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog act=%0d exp=<100000", cycles);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R10: reset, with drive requested, clears both registers and keeps ports quiet
      a_in = 8'hFF; b_in = 8'hEE; drive_en_n = 1'b0; toward_b = 1'b0;
      step(1, 1);
      step(1, 1);
      #1;
      chk("R10 a_oe in reset", a_oe, '0);
      chk("R10 b_oe in reset", b_oe, '0);
      rst = 1'b0;
      mon_on = 1'b1;
      read_regs("R10 cleared", 8'h00, 8'h00);

      // R1: capture while isolated
      drive_en_n = 1'b1; a_in = 8'hA5;
      step(1, 0);
      #1; chk("R3 isolated a_oe", a_oe, '0);
      read_regs("R1 isolated capture", 8'hA5, 8'h00);

      // R1: capture while B is the driven port
      drive_en_n = 1'b0; toward_b = 1'b1; b_use_reg = 1'b1; a_in = 8'h3C;
      step(1, 0);
      #1; chk("R1 capture while driving B", b_out, 8'h3C);

      // R2: capture while A is driven
      toward_b = 1'b0; a_use_reg = 1'b1; b_in = 8'h5A;
      step(0, 1);
      #1; chk("R2 capture while driving A", a_out, 8'h5A);

      // R2: capture of B input while B itself is driven
      toward_b = 1'b1; b_in = 8'h77;
      step(0, 1);
      toward_b = 1'b0; #1;
      chk("R2 capture while B driven", a_out, 8'h77);

      // R9: inputs change, no edges: stored values hold
      for (int k = 0; k < 6; k++) begin
         a_in = 8'(k * 37 + 1); b_in = 8'(k * 91 + 3);
         toward_b = k[0]; drive_en_n = k[1];
         step(0, 0);
      end
      read_regs("R9 hold", 8'h3C, 8'h77);

      // R11: simultaneous edges while isolated
      drive_en_n = 1'b1; a_in = 8'h81; b_in = 8'h18;
      step(1, 1);
      read_regs("R11 dual load", 8'h81, 8'h18);

      // R6 / R7: live paths under several patterns
      a_use_reg = 1'b0; b_use_reg = 1'b0; drive_en_n = 1'b0;
      for (int k = 0; k < 8; k++) begin
         a_in = 8'(1 << k); b_in = ~8'(1 << k);
         toward_b = 1'b0; #1; chk("R6 live B to A", a_out, b_in);
         toward_b = 1'b1; #1; chk("R7 live A to B", b_out, a_in);
         step(0, 0);
      end

      // mixed traffic, checked every cycle by the monitor
      for (int k = 0; k < 400; k++) begin
         a_in = 8'($urandom); b_in = 8'($urandom);
         drive_en_n = ($urandom % 4) == 0;
         toward_b = $urandom % 2; a_use_reg = $urandom % 2; b_use_reg = $urandom % 2;
         step($urandom % 2 == 1, $urandom % 3 == 0);
      end

      // R10: a later reset clears both registers again
      rst = 1'b1; step(1, 1); rst = 1'b0;
      read_regs("R10 second reset", 8'h00, 8'h00);

      step(0, 0);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule